// File: doc/BRIEF.md
# Power-Management Companion Register File

This block is the register file of a power-management companion device. A serial-bus slave in front of it turns bus frames into single-cycle read and write strobes with a 5-bit register index and 16-bit data. The file answers with registered read data. It drives a level interrupt towards the host and a one-cycle shutdown request towards the system controller.

Interrupts are held in a status word and a mask word. A mask bit at 1 blocks its source, and the mask comes out of reset fully blocking. Software acknowledges a source by writing a 1 to that bit of the status index, which toggles the bit. Hardware sources set status bits. These are a power-key pulse, headset and hook pulses (gated by two enable bits in control word 1), and any write to the converter index, which reports a finished sample.

The converter interface does not convert anything. It keeps a 4-bit channel selector and returns the selected channel's 10-bit value, taken from a bus of per-channel inputs, with the channel number packed above it. An identification word carries a variant bit taken from a strap input.

Top module: `pwr_companion_regs`

## Requirements
- R1: After reset the following hold: mask = 0xFFFF, interrupt status = 0x0000, irq_out = 0, shutdown_req = 0, calibration (index 0x06) = 0x0001, power status (index 0x16) = 0x0020, sample control (index 0x09) = 0x00FF, control words 1 and 2 = 0x0000.
- R2: A read of index 0x00 returns 0x0215 when variant_strap is 0 and 0x0295 when it is 1 (bit 7 follows the strap).
- R3: irq_out is high in the cycle after any write or event that leaves a status bit at 1 whose mask bit (index 0x02, read/write) is 0, and low otherwise.
- R4: A write to index 0x01 XORs the written data into the interrupt status. A read of index 0x01 returns the status unchanged.
- R5: A write to index 0x08 loads the channel from data bits 13:10 and sets status bit 8. A read of index 0x08 returns (channel << 10) | adc_values[channel*10 +: 10].
- R6: A write to index 0x09 clears every sample-control bit that is 1 in the data.
- R7: A write of 0x0000 to index 0x17 while bit 1 of control word 1 is set makes shutdown_req high for exactly the next cycle. Any other write there, or the same write with bit 1 clear, leaves it low.
- R8: A key_evt pulse sets status bit 0. Power status bit 5 becomes 0 if key_pressed is 1 and 1 if it is 0.
- R9: head_evt sets status bit 7 and hook_evt sets status bit 6, only when control word 1 bits 8 and 10 are both 1. Otherwise the pulse has no effect.
- R10: Indices 0x06, 0x0D and 0x0E read back the last value written to them.
- R11: Every index not listed above reads 0x0000, and a write to it changes no register.
- R12: When an event sets a status bit in the same cycle as a toggle write to index 0x01, the bit ends at 1. The other toggled bits still toggle.
- R13: rd_data changes only on the edge that samples rd_en = 1 and then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| reg_idx | input | 5 | Register index |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| variant_strap | input | 1 | Selects the variant bit of the identification word |
| key_evt | input | 1 | Power-key event pulse |
| key_pressed | input | 1 | Key state qualifying key_evt |
| head_evt | input | 1 | Headset event pulse |
| hook_evt | input | 1 | Hook event pulse |
| adc_values | input | 160 | Sixteen 10-bit channel values, channel n at bits n*10+9:n*10 |
| irq_out | output | 1 | Level interrupt |
| shutdown_req | output | 1 | One-cycle shutdown request |

## Verification
On every cycle the assertions check several rules. The interrupt line must agree with the stored status and mask. A shutdown pulse may appear only after a qualifying watchdog write. Key events and converter writes must leave their status bits at 1. Read data must stay stable between reads, and the mask and power status must start at their reset values. The bench's scenarios are needed for the data-dependent results. These are the read values of each index including the unimplemented ones, the channel packing across all sixteen channels, the clear-on-one sample control, the gating of headset and hook events, and the same-cycle priority of an event over a toggle.

// File: rtl/pwr_companion_pkg.sv
package pwr_companion_pkg;
  localparam int IDX_W = 5;

  localparam logic [IDX_W-1:0] IX_IDENT   = 5'h00;
  localparam logic [IDX_W-1:0] IX_IRQ_ST  = 5'h01;
  localparam logic [IDX_W-1:0] IX_IRQ_MSK = 5'h02;
  localparam logic [IDX_W-1:0] IX_CALIB   = 5'h06;
  localparam logic [IDX_W-1:0] IX_CONV    = 5'h08;
  localparam logic [IDX_W-1:0] IX_SAMPLE  = 5'h09;
  localparam logic [IDX_W-1:0] IX_CTRL1   = 5'h0D;
  localparam logic [IDX_W-1:0] IX_CTRL2   = 5'h0E;
  localparam logic [IDX_W-1:0] IX_PSTAT   = 5'h16;
  localparam logic [IDX_W-1:0] IX_WDOG    = 5'h17;

  // interrupt source bit positions
  localparam int SRC_KEY  = 0;
  localparam int SRC_HOOK = 6;
  localparam int SRC_HEAD = 7;
  localparam int SRC_CONV = 8;

  // control word 1 bit positions
  localparam int C1_SHUT_EN = 1;
  localparam int C1_JACK_A  = 8;
  localparam int C1_JACK_B  = 10;

  // power status bit driven by the key
  localparam int PS_KEY_UP = 5;
endpackage

// File: rtl/pwr_irq_unit.sv
module pwr_irq_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tgl_en,
  input  logic [W-1:0] tgl_val,
  input  logic         mask_we,
  input  logic [W-1:0] mask_val,
  input  logic [W-1:0] set_bits,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] mask_q,
  output logic         irq_q
);
  logic [W-1:0] stat_nx;
  logic [W-1:0] mask_nx;

  always_comb begin
    stat_nx = tgl_en ? (stat_q ^ tgl_val) : stat_q;
    stat_nx = stat_nx | set_bits;
    mask_nx = mask_we ? mask_val : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_nx;
      mask_q <= mask_nx;
      irq_q  <= |(stat_nx & ~mask_nx);
    end
  end
endmodule

// File: rtl/pwr_conv_port.sv
module pwr_conv_port #(
  parameter int W        = 16,
  parameter int CHANNELS = 16,
  parameter int RES_W    = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sel_we,
  input  logic [$clog2(CHANNELS)-1:0] sel_val,
  input  logic [CHANNELS*RES_W-1:0] adc_flat,
  output logic [W-1:0]              rd_word
);
  localparam int CW  = $clog2(CHANNELS);
  localparam int PAD = W - CW - RES_W;

  logic [RES_W-1:0] res_arr [CHANNELS];
  logic [CW-1:0]    chan_q;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_unpack
    assign res_arr[g] = adc_flat[g*RES_W +: RES_W];
  end

  always_ff @(posedge clk) begin
    if (rst)         chan_q <= '0;
    else if (sel_we) chan_q <= sel_val;
  end

  assign rd_word = {{PAD{1'b0}}, chan_q, res_arr[chan_q]};
endmodule

// File: rtl/pwr_ctrl_bank.sv
module pwr_ctrl_bank
  import pwr_companion_pkg::*;
#(
  parameter int          W           = 16,
  parameter logic [15:0] CALIB_INIT  = 16'h0001,
  parameter logic [15:0] SAMPLE_INIT = 16'h00FF,
  parameter logic [15:0] PSTAT_INIT  = 16'h0020
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wdata,
  input  logic             key_evt,
  input  logic             key_pressed,
  output logic [W-1:0]     calib_q,
  output logic [W-1:0]     ctrl1_q,
  output logic [W-1:0]     ctrl2_q,
  output logic [W-1:0]     sample_q,
  output logic [W-1:0]     pstat_q,
  output logic             shut_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      calib_q  <= CALIB_INIT[W-1:0];
      ctrl1_q  <= '0;
      ctrl2_q  <= '0;
      sample_q <= SAMPLE_INIT[W-1:0];
      pstat_q  <= PSTAT_INIT[W-1:0];
      shut_q   <= 1'b0;
    end else begin
      shut_q <= wr_en && (idx == IX_WDOG) && (wdata == '0) && ctrl1_q[C1_SHUT_EN];
      if (wr_en) begin
        case (idx)
          IX_CALIB:  calib_q  <= wdata;
          IX_CTRL1:  ctrl1_q  <= wdata;
          IX_CTRL2:  ctrl2_q  <= wdata;
          IX_SAMPLE: sample_q <= sample_q & ~wdata;
          default: ;
        endcase
      end
      if (key_evt) pstat_q[PS_KEY_UP] <= ~key_pressed;
    end
  end
endmodule

// File: rtl/pwr_companion_regs.sv
module pwr_companion_regs
  import pwr_companion_pkg::*;
#(
  parameter int          W          = 16,
  parameter int          CHANNELS   = 16,
  parameter int          RES_W      = 10,
  parameter logic [15:0] IDENT_BASE = 16'h0215,
  parameter int          VARIANT_BIT = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [IDX_W-1:0]          reg_idx,
  input  logic [W-1:0]              wr_data,
  output logic [W-1:0]              rd_data,
  input  logic                      variant_strap,
  input  logic                      key_evt,
  input  logic                      key_pressed,
  input  logic                      head_evt,
  input  logic                      hook_evt,
  input  logic [CHANNELS*RES_W-1:0] adc_values,
  output logic                      irq_out,
  output logic                      shutdown_req
);
  localparam int CW = $clog2(CHANNELS);

  logic [W-1:0] stat_q, mask_q, set_bits;
  logic [W-1:0] calib_q, ctrl1_q, ctrl2_q, sample_q, pstat_q;
  logic [W-1:0] conv_word, ident_word, rd_nx;
  logic         jack_en, conv_we;

  assign jack_en = ctrl1_q[C1_JACK_A] && ctrl1_q[C1_JACK_B];
  assign conv_we = wr_en && (reg_idx == IX_CONV);

  always_comb begin
    set_bits = '0;
    set_bits[SRC_KEY]  = key_evt;
    set_bits[SRC_HEAD] = head_evt && jack_en;
    set_bits[SRC_HOOK] = hook_evt && jack_en;
    set_bits[SRC_CONV] = conv_we;
  end

  pwr_irq_unit #(.W(W)) irq_i (
    .clk      (clk),
    .rst      (rst),
    .tgl_en   (wr_en && (reg_idx == IX_IRQ_ST)),
    .tgl_val  (wr_data),
    .mask_we  (wr_en && (reg_idx == IX_IRQ_MSK)),
    .mask_val (wr_data),
    .set_bits (set_bits),
    .stat_q   (stat_q),
    .mask_q   (mask_q),
    .irq_q    (irq_out)
  );

  pwr_conv_port #(.W(W), .CHANNELS(CHANNELS), .RES_W(RES_W)) conv_i (
    .clk      (clk),
    .rst      (rst),
    .sel_we   (conv_we),
    .sel_val  (wr_data[RES_W +: CW]),
    .adc_flat (adc_values),
    .rd_word  (conv_word)
  );

  pwr_ctrl_bank #(.W(W)) ctrl_i (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .idx         (reg_idx),
    .wdata       (wr_data),
    .key_evt     (key_evt),
    .key_pressed (key_pressed),
    .calib_q     (calib_q),
    .ctrl1_q     (ctrl1_q),
    .ctrl2_q     (ctrl2_q),
    .sample_q    (sample_q),
    .pstat_q     (pstat_q),
    .shut_q      (shutdown_req)
  );

  always_comb begin
    ident_word = IDENT_BASE[W-1:0];
    ident_word[VARIANT_BIT] = variant_strap;
    case (reg_idx)
      IX_IDENT:   rd_nx = ident_word;
      IX_IRQ_ST:  rd_nx = stat_q;
      IX_IRQ_MSK: rd_nx = mask_q;
      IX_CALIB:   rd_nx = calib_q;
      IX_CONV:    rd_nx = conv_word;
      IX_SAMPLE:  rd_nx = sample_q;
      IX_CTRL1:   rd_nx = ctrl1_q;
      IX_CTRL2:   rd_nx = ctrl2_q;
      IX_PSTAT:   rd_nx = pstat_q;
      default:    rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_nx;
  end
endmodule

// File: rtl/pwr_companion_chk.sv
module pwr_companion_chk
  import pwr_companion_pkg::*;
#(
  parameter int W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [IDX_W-1:0] reg_idx,
  input logic [W-1:0]     wr_data,
  input logic [W-1:0]     rd_data,
  input logic             key_evt,
  input logic             irq_out,
  input logic             shutdown_req,
  input logic [W-1:0]     stat_q,
  input logic [W-1:0]     mask_q,
  input logic [W-1:0]     ctrl1_q,
  input logic [W-1:0]     pstat_q
);
  p_irq_level_r3: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|(stat_q & ~mask_q)));

  p_shutdown_cause_r7: assert property (@(posedge clk) disable iff (rst)
    shutdown_req |-> $past(wr_en && reg_idx == IX_WDOG && wr_data == '0 && ctrl1_q[C1_SHUT_EN]));

  p_key_sets_r8: assert property (@(posedge clk) disable iff (rst)
    key_evt |=> stat_q[SRC_KEY]);

  p_event_wins_r12: assert property (@(posedge clk) disable iff (rst)
    (key_evt && wr_en && reg_idx == IX_IRQ_ST) |=> stat_q[SRC_KEY]);

  p_conv_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_idx == IX_CONV) |=> stat_q[SRC_CONV]);

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && stat_q == '0 && pstat_q == 16'h0020 && !shutdown_req));
endmodule

bind pwr_companion_regs pwr_companion_chk #(.W(W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .reg_idx      (reg_idx),
  .wr_data      (wr_data),
  .rd_data      (rd_data),
  .key_evt      (key_evt),
  .irq_out      (irq_out),
  .shutdown_req (shutdown_req),
  .stat_q       (stat_q),
  .mask_q       (mask_q),
  .ctrl1_q      (ctrl1_q),
  .pstat_q      (pstat_q)
);

// File: tb/pwr_companion_regs_tb.sv
module pwr_companion_regs_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 0, rd_en = 0;
  logic [4:0]   reg_idx = '0;
  logic [15:0]  wr_data = '0;
  logic [15:0]  rd_data;
  logic         variant_strap = 0;
  logic         key_evt = 0, key_pressed = 0, head_evt = 0, hook_evt = 0;
  logic [159:0] adc_values;
  logic         irq_out, shutdown_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  function automatic logic [9:0] chan_val(int ch);
    return 10'((ch * 37 + 5) & 10'h3FF);
  endfunction

  always_comb begin
    for (int c = 0; c < 16; c++) adc_values[c*10 +: 10] = chan_val(c);
  end

  pwr_companion_regs dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
    .wr_data(wr_data), .rd_data(rd_data), .variant_strap(variant_strap),
    .key_evt(key_evt), .key_pressed(key_pressed), .head_evt(head_evt),
    .hook_evt(hook_evt), .adc_values(adc_values), .irq_out(irq_out),
    .shutdown_req(shutdown_req)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] idx, logic [15:0] d);
    @(negedge clk);
    wr_en = 1; reg_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(logic [4:0] idx, output logic [15:0] v);
    @(negedge clk);
    rd_en = 1; reg_idx = idx;
    @(posedge clk); #1;
    rd_en = 0;
    v = rd_data;
  endtask

  task automatic rd_chk(string req, logic [4:0] idx, logic [15:0] exp);
    logic [15:0] v;
    rd(idx, v);
    chk(req, v, exp);
  endtask

  task automatic key(logic pressed);
    @(negedge clk);
    key_evt = 1; key_pressed = pressed;
    @(posedge clk); #1;
    key_evt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk("R1 irq", {15'd0, irq_out}, 16'd0);
    chk("R1 shutdown", {15'd0, shutdown_req}, 16'd0);
    rd_chk("R1 mask", 5'h02, 16'hFFFF);
    rd_chk("R1 status", 5'h01, 16'h0000);
    rd_chk("R1 calib", 5'h06, 16'h0001);
    rd_chk("R1 pstat", 5'h16, 16'h0020);
    rd_chk("R1 sample", 5'h09, 16'h00FF);
    rd_chk("R1 ctrl1", 5'h0D, 16'h0000);
    // R2 identification
    rd_chk("R2 strap0", 5'h00, 16'h0215);
    variant_strap = 1;
    rd_chk("R2 strap1", 5'h00, 16'h0295);
    variant_strap = 0;
    // R10 plain registers
    wr(5'h06, 16'h1234); rd_chk("R10 calib", 5'h06, 16'h1234);
    wr(5'h0E, 16'hBEEF); rd_chk("R10 ctrl2", 5'h0E, 16'hBEEF);
    wr(5'h0D, 16'h5A50); rd_chk("R10 ctrl1", 5'h0D, 16'h5A50);
    wr(5'h0D, 16'h0000);
    // R11 unimplemented indices
    for (int i = 0; i < 32; i++) begin
      if (!(i inside {0, 1, 2, 6, 8, 9, 13, 14, 22})) begin
        wr(5'(i), 16'hFFFF);
        rd_chk($sformatf("R11 idx %0d", i), 5'(i), 16'h0000);
      end
    end
    rd_chk("R11 calib kept", 5'h06, 16'h1234);
    rd_chk("R11 ctrl1 kept", 5'h0D, 16'h0000);
    rd_chk("R11 mask kept", 5'h02, 16'hFFFF);
    rd_chk("R11 status kept", 5'h01, 16'h0000);
    // R3 / R4 sweep of every status bit
    for (int b = 0; b < 16; b++) begin
      wr(5'h01, 16'(1 << b));
      chk($sformatf("R3 masked b%0d", b), {15'd0, irq_out}, 16'd0);
      rd_chk($sformatf("R4 toggle on b%0d", b), 5'h01, 16'(1 << b));
      wr(5'h02, ~16'(1 << b));
      chk($sformatf("R3 unmasked b%0d", b), {15'd0, irq_out}, 16'd1);
      wr(5'h02, 16'hFFFF);
      chk($sformatf("R3 remasked b%0d", b), {15'd0, irq_out}, 16'd0);
      wr(5'h01, 16'(1 << b));
      rd_chk($sformatf("R4 toggle off b%0d", b), 5'h01, 16'h0000);
    end
    wr(5'h02, 16'h0000);
    chk("R3 all open empty", {15'd0, irq_out}, 16'd0);
    // R5 converter channels
    for (int c = 0; c < 16; c++) begin
      wr(5'h08, 16'(16'hC3FF & ~16'h3C00) | 16'(c << 10));
      chk($sformatf("R5 irq ch%0d", c), {15'd0, irq_out}, 16'd1);
      rd_chk($sformatf("R5 read ch%0d", c), 5'h08, 16'(c << 10) | 16'(chan_val(c)));
      rd_chk($sformatf("R5 status ch%0d", c), 5'h01, 16'h0100);
      wr(5'h01, 16'h0100);
    end
    // R6 clear-on-one
    wr(5'h09, 16'h0F0F); rd_chk("R6 sample", 5'h09, 16'h00F0);
    wr(5'h09, 16'h0000); rd_chk("R6 zero write", 5'h09, 16'h00F0);
    // R7 watchdog
    wr(5'h17, 16'h0000);
    chk("R7 disabled", {15'd0, shutdown_req}, 16'd0);
    wr(5'h0D, 16'h0002);
    wr(5'h17, 16'h0005);
    chk("R7 nonzero", {15'd0, shutdown_req}, 16'd0);
    wr(5'h17, 16'h0000);
    chk("R7 pulse", {15'd0, shutdown_req}, 16'd1);
    @(posedge clk); #1;
    chk("R7 one cycle", {15'd0, shutdown_req}, 16'd0);
    // R8 power key
    key(1'b1);
    rd_chk("R8 pressed status", 5'h01, 16'h0001);
    rd_chk("R8 pressed pstat", 5'h16, 16'h0000);
    key(1'b0);
    rd_chk("R8 released pstat", 5'h16, 16'h0020);
    wr(5'h01, 16'h0001);
    // R9 jack gating
    wr(5'h0D, 16'h0100);
    @(negedge clk); head_evt = 1; hook_evt = 1; @(posedge clk); #1; head_evt = 0; hook_evt = 0;
    rd_chk("R9 gated off", 5'h01, 16'h0000);
    wr(5'h0D, 16'h0500);
    @(negedge clk); head_evt = 1; @(posedge clk); #1; head_evt = 0;
    rd_chk("R9 head", 5'h01, 16'h0080);
    @(negedge clk); hook_evt = 1; @(posedge clk); #1; hook_evt = 0;
    rd_chk("R9 hook", 5'h01, 16'h00C0);
    wr(5'h01, 16'h00C0);
    // R12 event beats toggle
    key(1'b1);
    @(negedge clk);
    wr_en = 1; reg_idx = 5'h01; wr_data = 16'h0003; key_evt = 1; key_pressed = 1;
    @(posedge clk); #1;
    wr_en = 0; key_evt = 0;
    rd_chk("R12 priority", 5'h01, 16'h0003);
    // R13 read hold
    rd_chk("R13 read", 5'h06, 16'h1234);
    @(negedge clk); reg_idx = 5'h00;
    repeat (3) @(posedge clk); #1;
    chk("R13 hold", rd_data, 16'h1234);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule